// File: doc/BRIEF.md
# Digitizer Capture Ring with Triggered Event Readout

This block is the per-channel capture memory of a flash digitizer. It collects 8-bit samples as they arrive and packs each group of four into one ring word. Each word also carries one extra bit: the discriminator (hit) state seen during those four samples. Writing never stops, so the ring always holds the recent history of both the waveform and the hit pattern.

On a trigger pulse the block computes a start address a programmable number of words behind the current write position. It copies a programmable number of words from that point into a local event buffer and adds up their pedestal-subtracted charge as it goes. It then presents a header word and, unless zero-suppression discards the payload, the captured words. The output uses a ready/valid handshake. A synchronous clear puts every channel back to the same starting state, so all channels stay aligned.

Top module: `flash_ring_capture`

## Requirements
- R1: Each ring word packs four consecutive valid samples. The oldest sample is in bits [7:0], the next in [15:8], then [23:16], and the newest in [31:24].
- R2: Bit 32 of a ring word is the OR of `disc_in` over the four sample-valid cycles that filled that word.
- R3: On an accepted trigger, the window starts at ring address (write pointer − `cfg_delay`) mod 256, where the write pointer is the address of the next word to be written. The window covers `cfg_len` words, 1 to 64, which are emitted in ascending address order.
- R4: Every event starts with a header beat marked by `out_hdr`=1. Bits [15:0] hold a 16-bit event counter, which is 0 for the first trigger after reset or clear and increments once per accepted trigger. Bits [22:16] hold the number of data words that follow. Bits [32:23] are zero.
- R5: When `cfg_zs_en` is 1, the charge is the sum over every sample in the window of max(sample − `cfg_ped`, 0). If the charge is strictly below `cfg_thr`, the header reports 0 words and no data follows. A charge equal to the threshold keeps the full window.
- R6: A trigger that arrives while an event is being scanned or emitted produces no event and increments `lost_cnt` by one.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_hdr` and `out_data` hold steady.
- R8: `clr` resets the write pointer, the partial sample group, the event counter and `lost_cnt`, and it aborts any readout. Samples that follow a clear fill ring address 0 first.
- R9: A window that runs past address 255 continues at address 0.
- R10: After reset, `out_valid` is 0 and `lost_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr | input | 1 | Synchronous clear shared by all channels |
| samp_in | input | 8 | Digitized sample |
| samp_vld | input | 1 | Sample strobe |
| disc_in | input | 1 | Discriminator state |
| trig | input | 1 | Trigger pulse |
| cfg_delay | input | 8 | Look-back from the write pointer, in words |
| cfg_len | input | 7 | Window length in words (1..64) |
| cfg_zs_en | input | 1 | Zero-suppression enable |
| cfg_ped | input | 8 | Pedestal subtracted from each sample |
| cfg_thr | input | 16 | Charge threshold |
| out_data | output | 33 | Header or ring word |
| out_hdr | output | 1 | Marks the header beat |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer accepts the beat |
| lost_cnt | output | 16 | Number of triggers dropped while busy |

## Verification
The assertions check four things on every cycle: the write pointer advances by exactly one for each completed word, an output beat stays frozen while it is stalled, every dropped trigger increments the lost counter, and a clear empties the output. They also check that the count field of every header lies within the window limit. Only the bench scenarios can show that the data is correct. This covers the packing order and hit bit, the address arithmetic including wrap-around, and the charge comparison at its exact threshold. These checks need a model of the sample history, so the bench compares each beat with a ring it keeps itself.

// File: rtl/frc_pkg.sv
package frc_pkg;
  localparam int SMP_W  = 8;
  localparam int GRP    = 4;
  localparam int WORD_W = SMP_W * GRP + 1;
  localparam int CHG_W  = SMP_W + $clog2(GRP);

  typedef logic [WORD_W-1:0] ring_word_t;
  typedef enum logic [1:0] {RD_IDLE, RD_SCAN, RD_HDR, RD_DATA} rd_state_t;

  // floored pedestal-subtracted charge of one four-sample word
  function automatic logic [CHG_W-1:0] grp_charge(ring_word_t w, logic [SMP_W-1:0] ped);
    logic [CHG_W-1:0] acc;
    acc = '0;
    for (int g = 0; g < GRP; g++) begin
      if (w[g*SMP_W +: SMP_W] > ped)
        acc = acc + CHG_W'(w[g*SMP_W +: SMP_W] - ped);
    end
    return acc;
  endfunction

  function automatic ring_word_t make_header(logic [15:0] evc, logic [6:0] n);
    ring_word_t h;
    h = '0;
    h[15:0]  = evc;
    h[22:16] = n;
    return h;
  endfunction
endpackage

// File: rtl/frc_packer.sv
module frc_packer
  import frc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [SMP_W-1:0]  samp,
  input  logic              vld,
  input  logic              disc,
  output logic              wr_en,
  output logic [AW-1:0]     wptr,
  output ring_word_t        wr_word
);
  localparam int LI_W = $clog2(GRP);

  logic [SMP_W-1:0] lane [GRP-1];
  logic [LI_W-1:0]  lane_idx;
  logic             hit_acc;

  assign wr_en = vld && (lane_idx == LI_W'(GRP - 1));

  always_comb begin
    wr_word = '0;
    for (int g = 0; g < GRP - 1; g++) wr_word[g*SMP_W +: SMP_W] = lane[g];
    wr_word[(GRP-1)*SMP_W +: SMP_W] = samp;
    wr_word[WORD_W-1] = hit_acc | disc;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      lane_idx <= '0;
      hit_acc  <= 1'b0;
      wptr     <= '0;
      for (int g = 0; g < GRP - 1; g++) lane[g] <= '0;
    end else if (vld) begin
      if (wr_en) begin
        lane_idx <= '0;
        hit_acc  <= 1'b0;
        wptr     <= wptr + AW'(1);
      end else begin
        lane[lane_idx] <= samp;
        lane_idx       <= lane_idx + LI_W'(1);
        hit_acc        <= hit_acc | disc;
      end
    end
  end
endmodule

// File: rtl/frc_ring_ram.sv
module frc_ring_ram
  import frc_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  ring_word_t    wdata,
  input  logic [AW-1:0] raddr,
  output ring_word_t    rdata
);
  ring_word_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/frc_reader.sv
module frc_reader
  import frc_pkg::*;
#(
  parameter int AW      = 8,
  parameter int WIN_MAX = 64,
  parameter int EVC_W   = 16,
  parameter int LOST_W  = 16,
  localparam int LEN_W  = $clog2(WIN_MAX + 1),
  localparam int IDX_W  = $clog2(WIN_MAX),
  localparam int SUM_W  = $clog2(WIN_MAX * GRP * ((1 << SMP_W) - 1) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              trig,
  input  logic [AW-1:0]     wptr,
  input  logic [AW-1:0]     cfg_delay,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_zs_en,
  input  logic [SMP_W-1:0]  cfg_ped,
  input  logic [SUM_W-1:0]  cfg_thr,
  output logic [AW-1:0]     rd_addr,
  input  ring_word_t        rd_data,
  output ring_word_t        out_data,
  output logic              out_hdr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LOST_W-1:0] lost_cnt,
  output logic              trig_accept,
  output logic              trig_drop
);
  rd_state_t         state;
  logic [AW-1:0]     base;
  logic [LEN_W-1:0]  iss, rcv, len_q, nwords;
  logic [IDX_W-1:0]  idx;
  logic              rv, zs_q, issue;
  logic [SMP_W-1:0]  ped_q;
  logic [SUM_W-1:0]  thr_q, sum, sum_next;
  logic [EVC_W-1:0]  evc, cur_evc;
  ring_word_t        evbuf [WIN_MAX];

  assign trig_accept = trig && (state == RD_IDLE);
  assign trig_drop   = trig && (state != RD_IDLE);
  assign issue       = (state == RD_SCAN) && (iss < len_q);
  assign rd_addr     = base + AW'(iss);
  assign sum_next    = sum + SUM_W'(grp_charge(rd_data, ped_q));

  assign out_valid = (state == RD_HDR) || (state == RD_DATA);
  assign out_hdr   = (state == RD_HDR);
  assign out_data  = (state == RD_HDR) ? make_header(16'(cur_evc), 7'(nwords)) : evbuf[idx];

  always_ff @(posedge clk) begin
    if ((state == RD_SCAN) && rv) evbuf[rcv[IDX_W-1:0]] <= rd_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      state    <= RD_IDLE;
      base     <= '0;
      iss      <= '0;
      rcv      <= '0;
      rv       <= 1'b0;
      sum      <= '0;
      len_q    <= '0;
      nwords   <= '0;
      idx      <= '0;
      zs_q     <= 1'b0;
      ped_q    <= '0;
      thr_q    <= '0;
      evc      <= '0;
      cur_evc  <= '0;
      lost_cnt <= '0;
    end else begin
      if (trig_drop) lost_cnt <= lost_cnt + LOST_W'(1);
      rv <= issue;
      if (issue) iss <= iss + LEN_W'(1);
      unique case (state)
        RD_IDLE: if (trig) begin
          base    <= wptr - cfg_delay;
          iss     <= '0;
          rcv     <= '0;
          sum     <= '0;
          len_q   <= cfg_len;
          zs_q    <= cfg_zs_en;
          ped_q   <= cfg_ped;
          thr_q   <= cfg_thr;
          cur_evc <= evc;
          evc     <= evc + EVC_W'(1);
          state   <= RD_SCAN;
        end
        RD_SCAN: if (rv) begin
          sum <= sum_next;
          rcv <= rcv + LEN_W'(1);
          if (rcv == len_q - LEN_W'(1)) begin
            nwords <= (zs_q && (sum_next < thr_q)) ? '0 : len_q;
            state  <= RD_HDR;
          end
        end
        RD_HDR: if (out_ready) begin
          idx   <= '0;
          state <= (nwords == '0) ? RD_IDLE : RD_DATA;
        end
        RD_DATA: if (out_ready) begin
          if (LEN_W'(idx) == nwords - LEN_W'(1)) state <= RD_IDLE;
          else idx <= idx + IDX_W'(1);
        end
        default: state <= RD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_ring_capture.sv
module flash_ring_capture
  import frc_pkg::*;
#(
  parameter int DEPTH   = 256,
  parameter int WIN_MAX = 64,
  parameter int EVC_W   = 16,
  parameter int LOST_W  = 16,
  localparam int AW     = $clog2(DEPTH),
  localparam int LEN_W  = $clog2(WIN_MAX + 1),
  localparam int SUM_W  = $clog2(WIN_MAX * GRP * ((1 << SMP_W) - 1) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [SMP_W-1:0]  samp_in,
  input  logic              samp_vld,
  input  logic              disc_in,
  input  logic              trig,
  input  logic [AW-1:0]     cfg_delay,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic              cfg_zs_en,
  input  logic [SMP_W-1:0]  cfg_ped,
  input  logic [SUM_W-1:0]  cfg_thr,
  output logic [WORD_W-1:0] out_data,
  output logic              out_hdr,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [LOST_W-1:0] lost_cnt
);
  logic          wr_en, trig_accept, trig_drop;
  logic [AW-1:0] wptr, rd_addr;
  ring_word_t    wr_word, rd_data;

  frc_packer #(.AW(AW)) u_pack (
    .clk(clk), .rst_n(rst_n), .clr(clr), .samp(samp_in), .vld(samp_vld),
    .disc(disc_in), .wr_en(wr_en), .wptr(wptr), .wr_word(wr_word)
  );

  frc_ring_ram #(.DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wptr), .wdata(wr_word),
    .raddr(rd_addr), .rdata(rd_data)
  );

  frc_reader #(.AW(AW), .WIN_MAX(WIN_MAX), .EVC_W(EVC_W), .LOST_W(LOST_W)) u_rd (
    .clk(clk), .rst_n(rst_n), .clr(clr), .trig(trig), .wptr(wptr),
    .cfg_delay(cfg_delay), .cfg_len(cfg_len), .cfg_zs_en(cfg_zs_en),
    .cfg_ped(cfg_ped), .cfg_thr(cfg_thr), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_data(out_data), .out_hdr(out_hdr), .out_valid(out_valid),
    .out_ready(out_ready), .lost_cnt(lost_cnt),
    .trig_accept(trig_accept), .trig_drop(trig_drop)
  );
endmodule

// File: rtl/frc_checker.sv
module frc_checker #(
  parameter int AW      = 8,
  parameter int WORD_W  = 33,
  parameter int EVC_W   = 16,
  parameter int LEN_W   = 7,
  parameter int WIN_MAX = 64,
  parameter int LOST_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              wr_en,
  input logic [AW-1:0]     wptr,
  input logic              trig_drop,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_hdr,
  input logic [WORD_W-1:0] out_data,
  input logic [LOST_W-1:0] lost_cnt
);
  p_ptr_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !clr |=> wptr == AW'($past(wptr) + AW'(1)));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !clr |=> out_valid && $stable(out_data) && $stable(out_hdr));

  p_lost_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_drop && !clr |=> lost_cnt == LOST_W'($past(lost_cnt) + LOST_W'(1)));

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid && lost_cnt == '0);

  p_hdr_fmt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_hdr |-> out_data[EVC_W +: LEN_W] <= LEN_W'(WIN_MAX)
                             && out_data[WORD_W-1:EVC_W+LEN_W] == '0);
endmodule

bind flash_ring_capture frc_checker #(
  .AW(AW), .WORD_W(frc_pkg::WORD_W), .EVC_W(EVC_W), .LEN_W(LEN_W),
  .WIN_MAX(WIN_MAX), .LOST_W(LOST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .wr_en(wr_en), .wptr(wptr),
  .trig_drop(trig_drop), .out_valid(out_valid), .out_ready(out_ready),
  .out_hdr(out_hdr), .out_data(out_data), .lost_cnt(lost_cnt)
);

// File: tb/flash_ring_capture_test.sv
`timescale 1ns/1ps
module flash_ring_capture_test;
  logic        clk = 0, rst_n = 0, clr = 0;
  logic [7:0]  samp_in = 0;
  logic        samp_vld = 0, disc_in = 0, trig = 0;
  logic [7:0]  cfg_delay = 0;
  logic [6:0]  cfg_len = 1;
  logic        cfg_zs_en = 0;
  logic [7:0]  cfg_ped = 0;
  logic [15:0] cfg_thr = 0;
  logic [32:0] out_data;
  logic        out_hdr, out_valid;
  logic        out_ready = 1;
  logic [15:0] lost_cnt;

  always #2 clk = ~clk;

  flash_ring_capture uut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .samp_in(samp_in), .samp_vld(samp_vld),
    .disc_in(disc_in), .trig(trig), .cfg_delay(cfg_delay), .cfg_len(cfg_len),
    .cfg_zs_en(cfg_zs_en), .cfg_ped(cfg_ped), .cfg_thr(cfg_thr),
    .out_data(out_data), .out_hdr(out_hdr), .out_valid(out_valid),
    .out_ready(out_ready), .lost_cnt(lost_cnt)
  );

  typedef struct packed { int groups; int dly; int len; int zs; int ped; int thr; } vec_t;
  localparam vec_t VT [6] = '{
    '{20,   8,  4, 0,   0,   0},  // R1 R2 R3 plain window
    '{10,  16, 16, 1,   0,   1},  // R5 kept
    '{ 5,  12,  8, 1, 255,   1},  // R5 suppressed
    '{ 5,   6,  6, 1,  60, 100},  // R5 mid pedestal
    '{240, 64, 64, 0,   0,   0},  // R9 wrap, max length
    '{ 3,   1,  1, 0,   0,   0}   // R3 newest word only
  };

  logic [32:0] mdl [256];
  int mwp = 0, k = 0, evc_m = 0, lost_m = 0;
  int nchk = 0, nfail = 0;

  task automatic chk(input bit ok, input string req, input logic [32:0] act, input logic [32:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] smp_of(int n); return 8'((n * 53 + 17) & 255); endfunction
  function automatic logic disc_of(int n); return (n % 11) == 3; endfunction

  task automatic push_group();
    logic [32:0] w;
    w = '0;
    for (int j = 0; j < 4; j++) begin
      @(negedge clk);
      samp_vld = 1; samp_in = smp_of(k); disc_in = disc_of(k);
      w[j*8 +: 8] = smp_of(k);
      w[32] = w[32] | disc_of(k);
      k++;
    end
    mdl[mwp] = w;
    mwp = (mwp + 1) % 256;
  endtask

  task automatic pulse_trig();
    @(negedge clk); trig = 1;
    @(negedge clk); trig = 0;
  endtask

  function automatic int window_charge(int start, int len, int ped);
    int s = 0;
    for (int i = 0; i < len; i++)
      for (int b = 0; b < 4; b++) begin
        int d = int'(mdl[(start + i) % 256][b*8 +: 8]) - ped;
        if (d > 0) s += d;
      end
    return s;
  endfunction

  task automatic run_event(input int dly, input int len, input int zs, input int ped,
                           input int thr, input int stall, input bit extra, input string tag);
    int start, cnt, t;
    logic [32:0] hexp;
    @(negedge clk);
    samp_vld = 0; disc_in = 0;
    cfg_delay = 8'(dly); cfg_len = 7'(len); cfg_zs_en = zs[0];
    cfg_ped = 8'(ped); cfg_thr = 16'(thr);
    start = (mwp - dly + 256) % 256;
    cnt = (zs != 0 && window_charge(start, len, ped) < thr) ? 0 : len;
    hexp = {10'd0, 7'(cnt), 16'(evc_m)};
    evc_m++;
    out_ready = (stall == 0);
    pulse_trig();
    t = 0;
    while (!out_valid && t < 300) begin @(negedge clk); t++; end
    chk(out_valid && out_hdr && out_data == hexp, {tag, " R4 header"}, out_data, hexp);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(out_valid && out_hdr && out_data == hexp, "R7 stalled header held", out_data, hexp);
    end
    if (extra) begin
      pulse_trig();
      lost_m++;
      chk(lost_cnt == 16'(lost_m), "R6 lost trigger count", 33'(lost_cnt), 33'(lost_m));
    end
    out_ready = 1;
    for (int i = 0; i < cnt; i++) begin
      @(negedge clk);
      chk(out_valid && !out_hdr && out_data == mdl[(start + i) % 256],
          {tag, " R1 R2 R3 data word"}, out_data, mdl[(start + i) % 256]);
    end
    @(negedge clk);
    chk(!out_valid, {tag, " R6 no further beat"}, 33'(out_valid), 33'(0));
  endtask

  initial begin
    #(4 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!out_valid, "R10 reset out_valid", 33'(out_valid), 33'(0));
    chk(lost_cnt == 0, "R10 reset lost_cnt", 33'(lost_cnt), 33'(0));

    foreach (VT[v]) begin
      for (int g = 0; g < VT[v].groups; g++) push_group();
      run_event(VT[v].dly, VT[v].len, VT[v].zs, VT[v].ped, VT[v].thr, 0, 0,
                $sformatf("vec%0d", v));
    end

    // R5 threshold equal to charge keeps the window, one more drops it
    begin
      int st, q;
      for (int g = 0; g < 5; g++) push_group();
      st = (mwp - 8 + 256) % 256;
      q = window_charge(st, 4, 100);
      run_event(8, 4, 1, 100, q, 0, 0, "R5 equal");
      run_event(8, 4, 1, 100, q + 1, 0, 0, "R5 above");
    end

    // R7 stalled output, R6 trigger while busy
    for (int g = 0; g < 4; g++) push_group();
    run_event(10, 5, 0, 0, 0, 5, 1, "R7 stall");

    // R8 clear mid-group, then first word lands at address 0 and counters restart
    @(negedge clk); samp_vld = 1; samp_in = 8'hAA;
    @(negedge clk); samp_in = 8'h55;
    @(negedge clk); samp_vld = 0; clr = 1;
    @(negedge clk); clr = 0;
    chk(lost_cnt == 0, "R8 lost_cnt cleared", 33'(lost_cnt), 33'(0));
    chk(!out_valid, "R8 output idle after clear", 33'(out_valid), 33'(0));
    mwp = 0; evc_m = 0; lost_m = 0;
    push_group();
    run_event(1, 1, 0, 0, 0, 0, 0, "R8 after clear");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule